// File: doc/BRIEF.md
# Trace Port Enable Controller

This block decides when an on-chip debug trace unit may run. A host switches the unit on through a JTAG-style test access port in two steps. First it loads an auxiliary-access instruction into the TAP instruction register. Then it loads a 10-bit command register with the trace-access code. The TAP state machine is outside this block. The block receives the decoded test-logic-reset state, the compliance pin level and the two update strobes, each with the value that was just shifted in.

The block keeps two flags. The auxiliary-select flag records the last instruction loaded. The enable state switches the trace unit on and, with it, the generation of debug status messages. While the unit is off, the block denies read and write access to the trace registers and forces the message data, start/end and message clock outputs to their idle levels. A TAP reset, a low level on the compliance pin or a power-on reset turns the unit off.

Top module: `trace_enable_ctrl`

## Requirements
- R1: An `ir_update` strobe sets the auxiliary-select flag when `ir_value` equals `AUX_IR` (default 4'hA), and clears the flag for any other value.
- R2: A `cmd_update` strobe that carries `ACCESS_CMD` (default 10'h07C, binary 00_0111_1100) while the auxiliary-select flag is set raises `trace_en` one clock edge later.
- R3: A `cmd_update` strobe with any other code leaves `trace_en` unchanged, whether it is high or low.
- R4: A `cmd_update` strobe that carries `ACCESS_CMD` while the auxiliary-select flag is clear has no effect.
- R5: While `tap_tlr` is high, `trace_en` and the auxiliary-select flag both clear at the next edge. A later access command therefore needs a new auxiliary instruction first.
- R6: While `tap_comply` is low, `trace_en` and the auxiliary-select flag both clear at the next edge, and no command can set them. The clear takes priority over the set.
- R7: A low level on `rst_n` clears `trace_en` at once, without waiting for a clock edge. After `rst_n` rises, strobes are ignored for two more clock edges.
- R8: While disabled, the outputs sit at their idle levels: `msg_data_o` is all zeros, `msg_se_o` is all ones and `msg_clk_o` is low. While enabled, all three pass their inputs through unchanged.
- R9: `reg_rd_gnt` and `reg_wr_gnt` follow their requests only while `trace_en` is high, and are 0 otherwise.
- R10: `status_msg_en` equals `trace_en` at all times.
- R11: A change on `ir_value` or `cmd_value` without its update strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asserted asynchronously |
| tap_tlr | input | 1 | TAP is in test-logic-reset state |
| tap_comply | input | 1 | TAP compliance pin level; low disables |
| ir_update | input | 1 | One-cycle strobe: instruction register updated |
| ir_value | input | IR_W | Instruction just loaded |
| cmd_update | input | 1 | One-cycle strobe: command register updated |
| cmd_value | input | CMD_W | Command code just loaded |
| reg_rd_req | input | 1 | Trace register read request |
| reg_wr_req | input | 1 | Trace register write request |
| msg_data_in | input | MDO_W | Message data from the trace unit |
| msg_se_in | input | MSEO_W | Message start/end from the trace unit |
| msg_clk_in | input | 1 | Message clock from the trace unit |
| trace_en | output | 1 | Trace unit enabled |
| status_msg_en | output | 1 | Debug status message generation enabled |
| reg_rd_gnt | output | 1 | Read access granted |
| reg_wr_gnt | output | 1 | Write access granted |
| msg_data_o | output | MDO_W | Gated message data |
| msg_se_o | output | MSEO_W | Gated message start/end |
| msg_clk_o | output | 1 | Gated message clock |

## Verification
Strobes, TAP reset and compliance changes take effect at the first rising edge that samples them. The bench applies each stimulus just after a falling edge, removes it at the next falling edge and reads every output there, half a period after the edge that updates the state. The gated outputs and grants follow the enable state with no extra register, so they are checked in that same sample. The asynchronous power-on clear is checked one nanosecond after `rst_n` falls, with no clock edge in between. The two-edge hold-off after release is checked by issuing a strobe on the first edge after release and showing that it has no effect.

// File: rtl/tpe_pkg.sv
package tpe_pkg;

  typedef enum logic {
    TPE_OFF = 1'b0,
    TPE_ON  = 1'b1
  } tpe_state_e;

  localparam int unsigned TPE_RST_STAGES = 2;

endpackage

// File: rtl/tpe_rst_sync.sv
module tpe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/tpe_sel_track.sv
module tpe_sel_track #(
  parameter int unsigned    IR_W   = 4,
  parameter logic [IR_W-1:0] AUX_IR = 4'hA
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            ir_update,
  input  logic [IR_W-1:0] ir_value,
  output logic            aux_sel
);

  logic sel_q;
  logic sel_d;
  logic sel_ld;

  always_comb begin
    sel_ld = clear | ir_update;
    sel_d  = sel_q;
    if (clear)          sel_d = 1'b0;
    else if (ir_update) sel_d = (ir_value == AUX_IR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (sel_ld) sel_q <= sel_d;
  end

  assign aux_sel = sel_q;

endmodule

// File: rtl/tpe_enable_fsm.sv
module tpe_enable_fsm
  import tpe_pkg::*;
#(
  parameter int unsigned      CMD_W      = 10,
  parameter logic [CMD_W-1:0] ACCESS_CMD = 10'h07C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             aux_sel,
  input  logic             cmd_update,
  input  logic [CMD_W-1:0] cmd_value,
  output logic             enabled
);

  tpe_state_e state_q;
  tpe_state_e state_d;
  logic       state_ld;
  logic       hit;

  always_comb begin
    hit     = cmd_update & aux_sel & (cmd_value == ACCESS_CMD);
    state_d = state_q;
    unique case (state_q)
      TPE_OFF: if (!clear && hit) state_d = TPE_ON;
      TPE_ON:  if (clear)         state_d = TPE_OFF;
      default:                    state_d = TPE_OFF;
    endcase
    state_ld = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= TPE_OFF;
    else if (state_ld) state_q <= state_d;
  end

  assign enabled = (state_q == TPE_ON);

endmodule

// File: rtl/tpe_out_gate.sv
module tpe_out_gate #(
  parameter int unsigned MDO_W  = 12,
  parameter int unsigned MSEO_W = 2
) (
  input  logic              enabled,
  input  logic              reg_rd_req,
  input  logic              reg_wr_req,
  input  logic [MDO_W-1:0]  msg_data_in,
  input  logic [MSEO_W-1:0] msg_se_in,
  input  logic              msg_clk_in,
  output logic              reg_rd_gnt,
  output logic              reg_wr_gnt,
  output logic [MDO_W-1:0]  msg_data_o,
  output logic [MSEO_W-1:0] msg_se_o,
  output logic              msg_clk_o
);

  // data lanes idle at 0
  for (genvar i = 0; i < MDO_W; i++) begin : g_data
    assign msg_data_o[i] = enabled & msg_data_in[i];
  end

  // start/end lanes idle at 1
  for (genvar j = 0; j < MSEO_W; j++) begin : g_se
    assign msg_se_o[j] = ~enabled | msg_se_in[j];
  end

  assign msg_clk_o  = enabled & msg_clk_in;
  assign reg_rd_gnt = enabled & reg_rd_req;
  assign reg_wr_gnt = enabled & reg_wr_req;

endmodule

// File: rtl/trace_enable_ctrl.sv
module trace_enable_ctrl
  import tpe_pkg::*;
#(
  parameter int unsigned      IR_W       = 4,
  parameter logic [IR_W-1:0]  AUX_IR     = 4'hA,
  parameter int unsigned      CMD_W      = 10,
  parameter logic [CMD_W-1:0] ACCESS_CMD = 10'h07C,
  parameter int unsigned      MDO_W      = 12,
  parameter int unsigned      MSEO_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tap_tlr,
  input  logic              tap_comply,
  input  logic              ir_update,
  input  logic [IR_W-1:0]   ir_value,
  input  logic              cmd_update,
  input  logic [CMD_W-1:0]  cmd_value,
  input  logic              reg_rd_req,
  input  logic              reg_wr_req,
  input  logic [MDO_W-1:0]  msg_data_in,
  input  logic [MSEO_W-1:0] msg_se_in,
  input  logic              msg_clk_in,
  output logic              trace_en,
  output logic              status_msg_en,
  output logic              reg_rd_gnt,
  output logic              reg_wr_gnt,
  output logic [MDO_W-1:0]  msg_data_o,
  output logic [MSEO_W-1:0] msg_se_o,
  output logic              msg_clk_o
);

  logic rst_n_sync;
  logic clear;
  logic aux_sel;
  logic enabled;

  assign clear = tap_tlr | ~tap_comply;

  tpe_rst_sync #(.STAGES(TPE_RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  tpe_sel_track #(.IR_W(IR_W), .AUX_IR(AUX_IR)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .clear     (clear),
    .ir_update (ir_update),
    .ir_value  (ir_value),
    .aux_sel   (aux_sel)
  );

  tpe_enable_fsm #(.CMD_W(CMD_W), .ACCESS_CMD(ACCESS_CMD)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .clear      (clear),
    .aux_sel    (aux_sel),
    .cmd_update (cmd_update),
    .cmd_value  (cmd_value),
    .enabled    (enabled)
  );

  tpe_out_gate #(.MDO_W(MDO_W), .MSEO_W(MSEO_W)) u_gate (
    .enabled     (enabled),
    .reg_rd_req  (reg_rd_req),
    .reg_wr_req  (reg_wr_req),
    .msg_data_in (msg_data_in),
    .msg_se_in   (msg_se_in),
    .msg_clk_in  (msg_clk_in),
    .reg_rd_gnt  (reg_rd_gnt),
    .reg_wr_gnt  (reg_wr_gnt),
    .msg_data_o  (msg_data_o),
    .msg_se_o    (msg_se_o),
    .msg_clk_o   (msg_clk_o)
  );

  assign trace_en      = enabled;
  assign status_msg_en = enabled;

endmodule

// File: rtl/tpe_checker.sv
module tpe_checker #(
  parameter int unsigned      CMD_W      = 10,
  parameter logic [CMD_W-1:0] ACCESS_CMD = 10'h07C,
  parameter int unsigned      MDO_W      = 12,
  parameter int unsigned      MSEO_W     = 2
) (
  input logic              clk,
  input logic              rst_n_sync,
  input logic              tap_tlr,
  input logic              tap_comply,
  input logic              ir_update,
  input logic              cmd_update,
  input logic [CMD_W-1:0]  cmd_value,
  input logic              aux_sel,
  input logic              trace_en,
  input logic              reg_rd_gnt,
  input logic              reg_wr_gnt,
  input logic [MDO_W-1:0]  msg_data_o,
  input logic [MSEO_W-1:0] msg_se_o,
  input logic              msg_clk_o
);

  a_r2_access_enables: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cmd_update && aux_sel && cmd_value == ACCESS_CMD && !tap_tlr && tap_comply) |=> trace_en);

  a_r3_other_code_holds: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cmd_update && cmd_value != ACCESS_CMD && !tap_tlr && tap_comply) |=> $stable(trace_en));

  a_r5_tlr_clears: assert property (@(posedge clk) disable iff (!rst_n_sync)
    tap_tlr |=> (!trace_en && !aux_sel));

  a_r6_comply_clears: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !tap_comply |=> (!trace_en && !aux_sel));

  a_r8_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !trace_en |-> (msg_data_o == '0 && msg_se_o == '1 && !msg_clk_o));

  a_r9_grant_needs_enable: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (reg_rd_gnt || reg_wr_gnt) |-> trace_en);

  a_r11_no_strobe_holds: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!cmd_update && !ir_update && !tap_tlr && tap_comply) |=> $stable(trace_en));

endmodule

bind trace_enable_ctrl tpe_checker #(
  .CMD_W(CMD_W), .ACCESS_CMD(ACCESS_CMD), .MDO_W(MDO_W), .MSEO_W(MSEO_W)
) u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .tap_tlr    (tap_tlr),
  .tap_comply (tap_comply),
  .ir_update  (ir_update),
  .cmd_update (cmd_update),
  .cmd_value  (cmd_value),
  .aux_sel    (aux_sel),
  .trace_en   (trace_en),
  .reg_rd_gnt (reg_rd_gnt),
  .reg_wr_gnt (reg_wr_gnt),
  .msg_data_o (msg_data_o),
  .msg_se_o   (msg_se_o),
  .msg_clk_o  (msg_clk_o)
);

// File: tb/tb_trace_enable_ctrl.sv
module tb_trace_enable_ctrl;

  localparam logic [11:0] DATA_PAT = 12'hA5C;
  localparam logic [1:0]  SE_PAT   = 2'b01;

  // ops: 0 idle, 1 IR load, 2 CMD load, 3 TAP reset, 4 compliance low
  // entry = {op[2:0], value[9:0], expected enable, requirement[3:0]}
  localparam int NV = 16;
  localparam logic [17:0] VEC [NV] = '{
    {3'd2, 10'h07C, 1'b0, 4'd4},   // R4 access code without aux
    {3'd1, 10'h00A, 1'b0, 4'd1},   // R1 aux instruction
    {3'd2, 10'h07D, 1'b0, 4'd3},   // R3 wrong code while off
    {3'd2, 10'h07C, 1'b1, 4'd2},   // R2 enable
    {3'd2, 10'h155, 1'b1, 4'd3},   // R3 wrong code while on
    {3'd1, 10'h003, 1'b1, 4'd1},   // R1 other instruction, enable kept
    {3'd2, 10'h000, 1'b1, 4'd3},
    {3'd3, 10'h000, 1'b0, 4'd5},   // R5 TAP reset
    {3'd2, 10'h07C, 1'b0, 4'd5},   // R5 aux flag was cleared
    {3'd1, 10'h00A, 1'b0, 4'd1},
    {3'd2, 10'h07C, 1'b1, 4'd2},
    {3'd4, 10'h000, 1'b0, 4'd6},   // R6 compliance low
    {3'd2, 10'h07C, 1'b0, 4'd6},   // R6 aux flag was cleared
    {3'd1, 10'h00A, 1'b0, 4'd1},
    {3'd1, 10'h003, 1'b0, 4'd1},   // R1 aux deselected again
    {3'd2, 10'h07C, 1'b0, 4'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tap_tlr, tap_comply, ir_update, cmd_update;
  logic [3:0]  ir_value;
  logic [9:0]  cmd_value;
  logic        reg_rd_req, reg_wr_req, msg_clk_in;
  logic [11:0] msg_data_in;
  logic [1:0]  msg_se_in;
  logic        trace_en, status_msg_en, reg_rd_gnt, reg_wr_gnt, msg_clk_o;
  logic [11:0] msg_data_o;
  logic [1:0]  msg_se_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  trace_enable_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tap_tlr(tap_tlr), .tap_comply(tap_comply),
    .ir_update(ir_update), .ir_value(ir_value), .cmd_update(cmd_update),
    .cmd_value(cmd_value), .reg_rd_req(reg_rd_req), .reg_wr_req(reg_wr_req),
    .msg_data_in(msg_data_in), .msg_se_in(msg_se_in), .msg_clk_in(msg_clk_in),
    .trace_en(trace_en), .status_msg_en(status_msg_en), .reg_rd_gnt(reg_rd_gnt),
    .reg_wr_gnt(reg_wr_gnt), .msg_data_o(msg_data_o), .msg_se_o(msg_se_o),
    .msg_clk_o(msg_clk_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R8 R9 R10 outputs follow the expected enable state
  task automatic chk_all(string tag, logic e);
    chk({tag, " trace_en"}, 32'(trace_en), 32'(e));
    chk({tag, " R10 status"}, 32'(status_msg_en), 32'(e));
    chk({tag, " R8 data"}, 32'(msg_data_o), e ? 32'(DATA_PAT) : 32'h0);
    chk({tag, " R8 se"}, 32'(msg_se_o), e ? 32'(SE_PAT) : 32'h3);
    chk({tag, " R8 clk"}, 32'(msg_clk_o), 32'(e));
    chk({tag, " R9 rd"}, 32'(reg_rd_gnt), 32'(e));
    chk({tag, " R9 wr"}, 32'(reg_wr_gnt), 32'(e));
  endtask

  task automatic step(int op, logic [9:0] val);
    @(negedge clk);
    case (op)
      1: begin ir_update = 1'b1; ir_value = val[3:0]; end
      2: begin cmd_update = 1'b1; cmd_value = val; end
      3: tap_tlr = 1'b1;
      4: tap_comply = 1'b0;
      default: ;
    endcase
    @(negedge clk);
    ir_update = 1'b0; cmd_update = 1'b0; tap_tlr = 1'b0; tap_comply = 1'b1;
  endtask

  task automatic enable_seq();
    step(1, 10'h00A);
    step(2, 10'h07C);
  endtask

  initial begin
    rst_n = 1'b0; tap_tlr = 1'b0; tap_comply = 1'b1;
    ir_update = 1'b0; cmd_update = 1'b0; ir_value = '0; cmd_value = '0;
    reg_rd_req = 1'b1; reg_wr_req = 1'b1; msg_clk_in = 1'b1;
    msg_data_in = DATA_PAT; msg_se_in = SE_PAT;
    repeat (3) @(negedge clk);
    chk_all("R7 reset state", 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R7 after release", 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(int'(VEC[i][17:15]), VEC[i][14:5]);
      chk_all($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][4]);
    end

    // R11: codes change without strobes
    step(1, 10'h00A);
    @(negedge clk); cmd_value = 10'h07C; ir_value = 4'h3;
    repeat (3) @(negedge clk);
    chk_all("R11 no strobe", 1'b0);
    step(2, 10'h07C);
    chk_all("R11 aux kept, strobe enables", 1'b1);

    // R6: access command while compliance is low
    step(3, 10'h000);
    step(1, 10'h00A);
    @(negedge clk);
    tap_comply = 1'b0; cmd_update = 1'b1; cmd_value = 10'h07C;
    @(negedge clk);
    tap_comply = 1'b1; cmd_update = 1'b0;
    chk_all("R6 clear beats set", 1'b0);

    // R7: asynchronous clear, then two-edge hold-off
    enable_seq();
    chk_all("R7 enabled before reset", 1'b1);
    @(negedge clk); #1 rst_n = 1'b0;
    #1 chk_all("R7 async clear", 1'b0);
    @(negedge clk); rst_n = 1'b1;
    ir_update = 1'b1; ir_value = 4'hA;
    @(negedge clk); ir_update = 1'b0;
    @(negedge clk);
    step(2, 10'h07C);
    chk_all("R7 strobe in hold-off ignored", 1'b0);
    enable_seq();
    chk_all("R7 enable after hold-off", 1'b1);

    // R8: pass-through with another pattern
    msg_data_in = 12'h3F0; msg_se_in = 2'b10; #1;
    chk("R8 data pass", 32'(msg_data_o), 32'h3F0);
    chk("R8 se pass", 32'(msg_se_o), 32'h2);
    msg_data_in = DATA_PAT; msg_se_in = SE_PAT;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule